// File: doc/BRIEF.md
# Serial Console Transmitter with Deferred Stop

This block serialises bytes onto a single transmit line for a console port. A byte written by software lands in a one-byte holding stage and is moved into a frame shifter as soon as the shifter is free. The shifter sends one bit per baud tick. The baud tick is a one-cycle enable supplied from outside at the bit rate. Each frame is a low start bit, then the eight data bits beginning with the least significant, then an optional parity bit, then a high stop bit.

Three one-cycle command inputs control the block. The first turns the transmitter on. The second turns it off, but only once every byte already accepted has left the line. The third aborts at once and returns the block to its power-up condition. Two status outputs tell software when another byte may be written and when nothing at all remains to be sent.

Top module: `serial_tx_core`

## Requirements
- R1: After reset the transmitter is off: txLine is 1, holdReady is 0 and txEmpty is 1. A write while the transmitter is off is ignored and no frame appears.
- R2: Once turned on with nothing written, the line stays at 1 whatever baud ticks arrive, and holdReady is 1.
- R3: A loaded frame starts at the next baud tick. From that tick txLine is 0 (start bit). Each later tick presents the next bit: data bit 0 up to data bit 7, then the stop bit at 1. The tick after the stop bit returns the line to idle 1.
- R4: With parityEn at 1, a parity bit is sent between data bit 7 and the stop bit. For parityOdd at 0 it is the XOR of the eight data bits (even parity). For parityOdd at 1 it is the inverse (odd parity). Both settings are taken when the byte enters the shifter.
- R5: With the shifter free, a written byte moves out of the holding stage within two clock edges of the write edge. holdReady then returns to 1 while that byte is still being sent.
- R6: holdReady is 0 while the holding stage holds a byte. txEmpty is 1 only when both the holding stage and the shifter are empty.
- R7: A stop command issued while bytes are pending lets the shifting byte and the held byte both complete in full. holdReady is 0 from the command onward. After the last stop bit the transmitter is off and ignores writes.
- R8: A stop command while idle turns the transmitter off at the next clock edge. A write presented in the same cycle as a stop command is ignored.
- R9: The abort command forces txLine to 1 at the next clock edge, even mid-frame. It discards any held byte and leaves the transmitter off, so txEmpty is 1 and holdReady is 0.
- R10: If the on and stop commands are asserted in the same cycle, the stop command wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle bit-rate enable |
| cmdEnable | input | 1 | Turn transmitter on (pulse) |
| cmdDisable | input | 1 | Deferred stop request (pulse) |
| cmdReset | input | 1 | Immediate abort to power-up state (pulse) |
| parityEn | input | 1 | Insert a parity bit |
| parityOdd | input | 1 | Odd (1) or even (0) parity |
| wrValid | input | 1 | Write strobe for wrData |
| wrData | input | 8 | Byte to send |
| txLine | output | 1 | Serial transmit line, idle high |
| holdReady | output | 1 | Holding stage can accept a byte |
| txEmpty | output | 1 | Holding stage and shifter both empty |

## Verification
A stale holding-stage flag shows on holdReady one clock edge after the write or transfer that should have changed it. A held byte wrongly kept after an abort shows as an unexpected start bit at the first baud tick after the block is turned on again. A shifter bit counter that is off by one shows on txLine at the tick where the stop or parity bit is due. A deferred stop that ends too early cuts off the second frame within one bit time. The bench samples txLine after every tick, so each of these faults appears within one bit of the point where it occurs.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic holdWrite;   // capture wrData into holding stage
    logic shiftLoad;   // move holding stage into the frame shifter
    logic abort;       // drop the frame in progress
  } txStrobe_t;
endpackage

// File: rtl/serial_tx_datapath.sv
module serial_tx_datapath
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              baudTick,
  output logic              shiftBusy,
  output logic              txLine
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  holdData;
  logic [FRAME_W-1:0] frameBits;
  logic [FRAME_W-1:0] nextFrame;
  logic [CNT_W-1:0]   bitsLeft;
  logic [CNT_W-1:0]   nextCount;
  logic               started;
  logic               busy;
  logic               parityBit;

  always_comb begin
    parityBit = (^holdData) ^ parityOdd;
    if (parityEn) begin
      nextFrame = {1'b1, parityBit, holdData, 1'b0};
      nextCount = CNT_W'(DATA_W + 3);
    end else begin
      nextFrame = {1'b1, 1'b1, holdData, 1'b0};
      nextCount = CNT_W'(DATA_W + 2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData  <= '0;
      frameBits <= '1;
      bitsLeft  <= '0;
      started   <= 1'b0;
      busy      <= 1'b0;
    end else begin
      if (strobe.holdWrite) holdData <= wrData;
      if (strobe.abort) begin
        frameBits <= '1;
        bitsLeft  <= '0;
        started   <= 1'b0;
        busy      <= 1'b0;
      end else if (strobe.shiftLoad) begin
        frameBits <= nextFrame;
        bitsLeft  <= nextCount;
        started   <= 1'b0;
        busy      <= 1'b1;
      end else if (busy && baudTick) begin
        if (!started) begin
          started <= 1'b1;
        end else if (bitsLeft == CNT_W'(1)) begin
          busy      <= 1'b0;
          started   <= 1'b0;
          frameBits <= '1;
        end else begin
          frameBits <= {1'b1, frameBits[FRAME_W-1:1]};
          bitsLeft  <= bitsLeft - CNT_W'(1);
        end
      end
    end
  end

  assign shiftBusy = busy;
  assign txLine    = ~started | frameBits[0];

  AST_LINE_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);  // R1
  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(started) |-> $past(baudTick));  // R3
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abort |=> (!busy && txLine));  // R9
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftLoad |-> !busy);  // R5
endmodule

// File: rtl/serial_tx_control.sv
module serial_tx_control
  import serial_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdEnable,
  input  logic      cmdDisable,
  input  logic      cmdReset,
  input  logic      wrValid,
  input  logic      shiftBusy,
  output txStrobe_t strobe,
  output logic      holdReady,
  output logic      txEmpty
);
  logic enabled;
  logic stopPending;
  logic holdFull;

  always_comb begin
    holdReady        = enabled & ~stopPending & ~holdFull;
    txEmpty          = ~holdFull & ~shiftBusy;
    strobe.holdWrite = wrValid & holdReady & ~cmdDisable & ~cmdReset;
    strobe.shiftLoad = enabled & holdFull & ~shiftBusy & ~cmdReset;
    strobe.abort     = cmdReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled     <= 1'b0;
      stopPending <= 1'b0;
      holdFull    <= 1'b0;
    end else if (cmdReset) begin
      enabled     <= 1'b0;
      stopPending <= 1'b0;
      holdFull    <= 1'b0;
    end else begin
      if (strobe.shiftLoad)      holdFull <= 1'b0;
      else if (strobe.holdWrite) holdFull <= 1'b1;

      if (cmdDisable) begin
        if (txEmpty) begin
          enabled     <= 1'b0;
          stopPending <= 1'b0;
        end else begin
          stopPending <= 1'b1;
        end
      end else if (cmdEnable) begin
        enabled     <= 1'b1;
        stopPending <= 1'b0;
      end else if (stopPending && txEmpty) begin
        enabled     <= 1'b0;
        stopPending <= 1'b0;
      end
    end
  end

  AST_OFF_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> (!shiftBusy && !holdFull));  // R7
  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable && cmdDisable && txEmpty) |=> !enabled);  // R10
  AST_HOLD_DRAINS_TO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(holdFull) && !$past(cmdReset)) |-> shiftBusy);  // R5
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cmdReset |=> (!holdReady && txEmpty));  // R9
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              cmdReset,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine,
  output logic              holdReady,
  output logic              txEmpty
);
  txStrobe_t strobe;
  logic      shiftBusy;

  serial_tx_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdEnable  (cmdEnable),
    .cmdDisable (cmdDisable),
    .cmdReset   (cmdReset),
    .wrValid    (wrValid),
    .shiftBusy  (shiftBusy),
    .strobe     (strobe),
    .holdReady  (holdReady),
    .txEmpty    (txEmpty)
  );

  serial_tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .baudTick  (baudTick),
    .shiftBusy (shiftBusy),
    .txLine    (txLine)
  );
endmodule

// File: tb/tb_serial_tx_core.sv
`timescale 1ns/1ps
module tb_serial_tx_core;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       cmdEnable = 1'b0;
  logic       cmdDisable = 1'b0;
  logic       cmdReset = 1'b0;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       txLine;
  logic       holdReady;
  logic       txEmpty;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_tx_core dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReset(cmdReset),
    .parityEn(parityEn), .parityOdd(parityOdd),
    .wrValid(wrValid), .wrData(wrData),
    .txLine(txLine), .holdReady(holdReady), .txEmpty(txEmpty)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick();
    baudTick = 1'b1; step(); baudTick = 1'b0;
  endtask

  task automatic pulseEnable();
    cmdEnable = 1'b1; step(); cmdEnable = 1'b0;
  endtask

  task automatic pulseDisable();
    cmdDisable = 1'b1; step(); cmdDisable = 1'b0;
  endtask

  task automatic pulseReset();
    cmdReset = 1'b1; step(); cmdReset = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] d);
    wrData = d; wrValid = 1'b1; step(); wrValid = 1'b0;
  endtask

  // ticks through one full frame, checking every bit, ends back at idle
  task automatic checkFrame(input logic [7:0] d, input logic pe, input logic po, input string req);
    step(); step();
    tick(); chk({req, " start"}, {7'd0, txLine}, 8'd0);
    for (int i = 0; i < 8; i++) begin
      tick(); chk({req, " data"}, {7'd0, txLine}, {7'd0, d[i]});
    end
    if (pe) begin
      tick(); chk({req, " parity"}, {7'd0, txLine}, {7'd0, (^d) ^ po});
    end
    tick(); chk({req, " stop"}, {7'd0, txLine}, 8'd1);
    tick(); chk({req, " idle"}, {7'd0, txLine}, 8'd1);
  endtask

  task automatic testReset();
    chk("R1 line", {7'd0, txLine}, 8'd1);
    chk("R1 ready", {7'd0, holdReady}, 8'd0);
    chk("R1 empty", {7'd0, txEmpty}, 8'd1);
    writeByte(8'h55);
    for (int i = 0; i < 4; i++) begin
      tick(); chk("R1 ignored write", {7'd0, txLine}, 8'd1);
    end
    chk("R1 empty after write", {7'd0, txEmpty}, 8'd1);
  endtask

  task automatic testIdleEnabled();
    pulseEnable();
    chk("R2 ready", {7'd0, holdReady}, 8'd1);
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R2 idle line", {7'd0, txLine}, 8'd1);
    end
  endtask

  task automatic testFrames();
    parityEn = 1'b0;
    writeByte(8'hA5); checkFrame(8'hA5, 1'b0, 1'b0, "R3 A5");
    writeByte(8'h3C); checkFrame(8'h3C, 1'b0, 1'b0, "R3 3C");
    parityEn = 1'b1; parityOdd = 1'b0;
    writeByte(8'h07); checkFrame(8'h07, 1'b1, 1'b0, "R4 even");
    parityOdd = 1'b1;
    writeByte(8'h03); checkFrame(8'h03, 1'b1, 1'b1, "R4 odd");
    parityEn = 1'b0; parityOdd = 1'b0;
    chk("R6 empty after frames", {7'd0, txEmpty}, 8'd1);
  endtask

  task automatic testGracefulStop();
    writeByte(8'hC3);
    chk("R6 ready low while held", {7'd0, holdReady}, 8'd0);
    chk("R6 not empty while held", {7'd0, txEmpty}, 8'd0);
    step();
    chk("R5 ready back after transfer", {7'd0, holdReady}, 8'd1);
    chk("R6 not empty while shifting", {7'd0, txEmpty}, 8'd0);
    writeByte(8'h5A);
    chk("R6 ready low with both full", {7'd0, holdReady}, 8'd0);
    pulseDisable();
    chk("R7 ready low after stop", {7'd0, holdReady}, 8'd0);
    checkFrame(8'hC3, 1'b0, 1'b0, "R7 first");
    checkFrame(8'h5A, 1'b0, 1'b0, "R7 second");
    chk("R7 empty at end", {7'd0, txEmpty}, 8'd1);
    step();
    chk("R7 off ready", {7'd0, holdReady}, 8'd0);
    writeByte(8'h00);
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R7 off line", {7'd0, txLine}, 8'd1);
    end
  endtask

  task automatic testIdleStop();
    pulseEnable();
    chk("R8 ready before", {7'd0, holdReady}, 8'd1);
    wrData = 8'h00; wrValid = 1'b1; cmdDisable = 1'b1;
    step();
    wrValid = 1'b0; cmdDisable = 1'b0;
    chk("R8 ready off", {7'd0, holdReady}, 8'd0);
    chk("R8 same-cycle write dropped", {7'd0, txEmpty}, 8'd1);
    writeByte(8'h00);
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R8 line", {7'd0, txLine}, 8'd1);
    end
  endtask

  task automatic testAbort();
    pulseEnable();
    writeByte(8'h00);
    step(); step();
    tick(); tick(); tick();
    chk("R9 mid-frame low", {7'd0, txLine}, 8'd0);
    writeByte(8'hFF);
    chk("R9 held byte present", {7'd0, holdReady}, 8'd0);
    pulseReset();
    chk("R9 line high", {7'd0, txLine}, 8'd1);
    chk("R9 empty", {7'd0, txEmpty}, 8'd1);
    chk("R9 ready off", {7'd0, holdReady}, 8'd0);
    pulseEnable();
    chk("R9 hold discarded", {7'd0, holdReady}, 8'd1);
    for (int i = 0; i < 4; i++) begin
      tick(); chk("R9 no frame after abort", {7'd0, txLine}, 8'd1);
    end
    pulseDisable();
  endtask

  task automatic testConflict();
    cmdEnable = 1'b1; cmdDisable = 1'b1;
    step();
    cmdEnable = 1'b0; cmdDisable = 1'b0;
    chk("R10 stop wins", {7'd0, holdReady}, 8'd0);
    writeByte(8'h00);
    tick(); tick();
    chk("R10 line", {7'd0, txLine}, 8'd1);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    testReset();
    testIdleEnabled();
    testFrames();
    testGracefulStop();
    testIdleStop();
    testAbort();
    testConflict();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule